// File: doc/BRIEF.md
# Asynchronous Serial Transmitter with Programmable Line Format

This block turns bytes into asynchronous serial frames on a single TX line. Software sets the frame shape through a byte-wide register write port. It picks the number of data bits, the stop length, the parity mode and a break condition. A latch-access bit in the same register sends writes to two low addresses into a 16-bit baud divisor instead.

Bytes enter through a valid/ready handshake. One byte is accepted only when the transmitter is idle. The format in force at that moment is captured and held for the whole frame. An internal divider produces a sub-bit tick every `divisor` clocks, and every bit lasts 16 of those ticks.

When the break bit is set, the line is forced low and no new bytes are accepted. After break is cleared, the line rests high for one full bit time before the next frame can begin.

Top module: `async_tx_core`

## Requirements
- R1: After reset the line is high, `busy_o` is 0, `in_ready` is 1, the divisor is `DIV_INIT`, and every line-control bit is 0. That gives 5 data bits, 1 stop bit and no parity.
- R2: A frame is one start bit at 0, then the data bits least significant first, then optional parity, then the stop level at 1. The data-bit count comes from line-control bits [1:0]: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8.
- R3: Line-control bit 2 at 0 gives a stop time of 16 ticks. At 1 it gives 24 ticks for a 5-bit word and 32 ticks for 6, 7 or 8 bits. A held-valid next frame starts exactly one clock after the stop time ends.
- R4: With bit 3 = 1 and bit 5 = 0, a parity bit follows the data. Bit 4 = 0 makes the count of ones over data plus parity odd; bit 4 = 1 makes it even. With bit 3 = 0 no parity bit is sent.
- R5: With bits 3 and 5 both at 1, the parity bit is fixed: it is 1 when bit 4 is 0 and 0 when bit 4 is 1.
- R6: While line-control bit 6 is 1, the TX line is 0 from the next clock on. This holds whether or not a frame is in progress.
- R7: After break is cleared, with or without a frame in flight, the line is high for at least 16 ticks before the next start bit.
- R8: With line-control bit 7 = 1, writes to address 0 and address 1 load the divisor's low and high bytes. With bit 7 = 0, writes to those addresses leave the divisor unchanged. The line-control register sits at address 3 and is always writable.
- R9: One bit lasts 16 × divisor clocks. A divisor of 0 behaves as 1.
- R10: A line-control write during a frame does not alter that frame. It applies from the next accepted byte.
- R11: `in_ready` is 1 only when no frame, post-break gap or break is in progress. `busy_o` is 1 for all of those.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | AW | Register address (0/1 divisor bytes, 3 line control) |
| cfg_wdata | input | 8 | Register write data |
| in_valid | input | 1 | Byte offered for transmission |
| in_data | input | 8 | Byte to send (unused upper bits ignored) |
| in_ready | output | 1 | Byte accepted when high with `in_valid` |
| tx_o | output | 1 | Serial line, idle high |
| busy_o | output | 1 | Frame, gap or break in progress |

## Verification
A wrong tick or bit counter shows as a wrong frame length. The distance between the start edges of two back-to-back frames moves by whole ticks, which is visible within one frame. A wrong format snapshot or parity selection corrupts a bit sampled at its centre in the frame it affects. A wrong break state shows either as a high sample on the line within a cycle of setting break, or as a rest period of the wrong length before the next start edge.

// File: rtl/async_tx_pkg.sv
package async_tx_pkg;

  // Line-control layout; bit positions are software visible.
  typedef struct packed {
    logic       dlab;    // [7] divisor latch access
    logic       brk;     // [6] force line low
    logic       stick;   // [5] fixed parity
    logic       even;    // [4] even sense / fixed value select
    logic       par_en;  // [3] parity bit present
    logic       stop2;   // [2] long stop
    logic [1:0] wlen;    // [1:0] data bits minus five
  } lcr_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_START, ST_DATA, ST_PAR, ST_STOP, ST_GAP
  } tx_state_e;

endpackage

// File: rtl/async_tx_regs.sv
module async_tx_regs
  import async_tx_pkg::*;
#(
  parameter int DIV_W    = 16,
  parameter int DIV_INIT = 1,
  parameter int AW       = 2,
  parameter int LCR_ADDR = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [AW-1:0]    addr,
  input  logic [7:0]       wdata,
  output lcr_t             lcr_o,
  output logic [DIV_W-1:0] div_o
);
  localparam int NB = (DIV_W + 7) / 8;
  localparam logic [NB*8-1:0] INIT_V = (NB*8)'(DIV_INIT);

  logic [7:0]      div_b [NB];
  logic [NB*8-1:0] div_flat;

  always_ff @(posedge clk) begin
    if (rst) lcr_o <= '0;
    else if (we && addr == AW'(LCR_ADDR)) lcr_o <= lcr_t'(wdata);
  end

  for (genvar b = 0; b < NB; b++) begin : g_div
    always_ff @(posedge clk) begin
      if (rst) div_b[b] <= INIT_V[b*8 +: 8];
      else if (we && lcr_o.dlab && addr == AW'(b)) div_b[b] <= wdata;
    end
  end

  always_comb begin
    for (int b = 0; b < NB; b++) div_flat[b*8 +: 8] = div_b[b];
  end

  assign div_o = div_flat[DIV_W-1:0];

  AST_DIV_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (we && !lcr_o.dlab && addr != AW'(LCR_ADDR)) |=> $stable(div_o)); // R8

endmodule

// File: rtl/async_tx_tick.sv
module async_tx_tick #(
  parameter int DIV_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [DIV_W-1:0] divisor_i,
  input  logic             sync_i,
  output logic             tick_o
);
  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] div_m1;

  assign div_m1 = (divisor_i == '0) ? '0 : divisor_i - 1'b1;
  assign tick_o = !sync_i && (cnt >= div_m1);

  always_ff @(posedge clk) begin
    if (rst || sync_i)       cnt <= '0;
    else if (cnt >= div_m1)  cnt <= '0;
    else                     cnt <= cnt + 1'b1;
  end

  AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
    (tick_o && div_m1 != '0) |=> (!tick_o || !$stable(divisor_i))); // R9

endmodule

// File: rtl/async_tx_frame.sv
module async_tx_frame
  import async_tx_pkg::*;
#(
  parameter int OVS = 16
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick_i,
  input  lcr_t       lcr_i,
  input  logic       in_valid,
  input  logic [7:0] in_data,
  output logic       in_ready,
  output logic       sync_o,
  output logic       tx_o,
  output logic       busy_o
);
  localparam int CW = $clog2(2*OVS) + 1;

  tx_state_e     state;
  lcr_t          fmt_q;
  logic [7:0]    data_q;
  logic [7:0]    masked;
  logic [2:0]    bidx;
  logic [2:0]    last_idx;
  logic [CW-1:0] tcnt;
  logic [CW-1:0] stop_lim;
  logic [CW-1:0] lim;
  logic          brk_hit;
  logic          par_bit;
  logic          line;
  logic          accept;

  assign in_ready = (state == ST_IDLE) && !lcr_i.brk;
  assign accept   = in_valid && in_ready;
  assign sync_o   = accept || (state == ST_GAP && lcr_i.brk);
  assign busy_o   = (state != ST_IDLE);

  always_comb begin
    last_idx = 3'd4 + {1'b0, fmt_q.wlen};
    for (int i = 0; i < 8; i++) masked[i] = data_q[i] & (3'(i) <= last_idx);
    if (fmt_q.stick)     par_bit = ~fmt_q.even;
    else if (fmt_q.even) par_bit = ^masked;
    else                 par_bit = ~^masked;
    if (!fmt_q.stop2)              stop_lim = CW'(OVS - 1);
    else if (fmt_q.wlen == 2'b00)  stop_lim = CW'(OVS + OVS/2 - 1);
    else                           stop_lim = CW'(2*OVS - 1);
    lim = (state == ST_STOP) ? stop_lim : CW'(OVS - 1);
    case (state)
      ST_START: line = 1'b0;
      ST_DATA:  line = data_q[bidx];
      ST_PAR:   line = par_bit;
      default:  line = 1'b1;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= ST_IDLE;
      fmt_q   <= '0;
      data_q  <= '0;
      bidx    <= '0;
      tcnt    <= '0;
      brk_hit <= 1'b0;
      tx_o    <= 1'b1;
    end else begin
      tx_o <= lcr_i.brk ? 1'b0 : line;
      if (lcr_i.brk) brk_hit <= 1'b1;
      case (state)
        ST_IDLE: begin
          tcnt <= '0;
          bidx <= '0;
          if (lcr_i.brk) begin
            state <= ST_GAP;
          end else if (in_valid) begin
            state  <= ST_START;
            fmt_q  <= lcr_i;
            data_q <= in_data;
          end
        end
        ST_GAP: begin
          if (lcr_i.brk) begin
            tcnt <= '0;
          end else if (tick_i) begin
            if (tcnt == CW'(OVS - 1)) begin
              tcnt    <= '0;
              state   <= ST_IDLE;
              brk_hit <= 1'b0;
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
        default: begin
          if (tick_i) begin
            if (tcnt == lim) begin
              tcnt <= '0;
              case (state)
                ST_START: state <= ST_DATA;
                ST_DATA: begin
                  if (bidx == last_idx) state <= fmt_q.par_en ? ST_PAR : ST_STOP;
                  else                  bidx  <= bidx + 1'b1;
                end
                ST_PAR:  state <= ST_STOP;
                default: state <= (brk_hit || lcr_i.brk) ? ST_GAP : ST_IDLE;
              endcase
            end else begin
              tcnt <= tcnt + 1'b1;
            end
          end
        end
      endcase
    end
  end

  AST_BREAK_LOW: assert property (@(posedge clk) disable iff (rst)
    lcr_i.brk |=> !tx_o); // R6
  AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
    accept |-> ##2 !tx_o); // R2
  AST_FMT_HELD: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(fmt_q)); // R10

endmodule

// File: rtl/async_tx_core.sv
module async_tx_core
  import async_tx_pkg::*;
#(
  parameter int OVS      = 16,
  parameter int DIV_W    = 16,
  parameter int DIV_INIT = 1,
  parameter int AW       = 2,
  parameter int LCR_ADDR = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [7:0]    cfg_wdata,
  input  logic          in_valid,
  input  logic [7:0]    in_data,
  output logic          in_ready,
  output logic          tx_o,
  output logic          busy_o
);
  lcr_t             lcr;
  logic [DIV_W-1:0] divisor;
  logic             tick;
  logic             sync;

  async_tx_regs #(
    .DIV_W(DIV_W), .DIV_INIT(DIV_INIT), .AW(AW), .LCR_ADDR(LCR_ADDR)
  ) i_regs (
    .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
    .lcr_o(lcr), .div_o(divisor)
  );

  async_tx_tick #(.DIV_W(DIV_W)) i_tick (
    .clk(clk), .rst(rst), .divisor_i(divisor), .sync_i(sync), .tick_o(tick)
  );

  async_tx_frame #(.OVS(OVS)) i_frame (
    .clk(clk), .rst(rst), .tick_i(tick), .lcr_i(lcr),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
    .sync_o(sync), .tx_o(tx_o), .busy_o(busy_o)
  );

  AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
    in_ready |-> !busy_o); // R11

endmodule

// File: tb/test_async_tx_core.sv
module test_async_tx_core;
  localparam int CLK_PERIOD = 10;
  localparam int LCR_A = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cfg_we = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] cfg_wdata = '0;
  logic       in_valid = 1'b0;
  logic [7:0] in_data = '0;
  logic       in_ready, tx_o, busy_o;
  int         cyc = 0;
  int         n_tests = 0;
  int         n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  async_tx_core i_async_tx_core (
    .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .tx_o(tx_o), .busy_o(busy_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int stop_ticks(input logic [7:0] l);
    if (!l[2]) return 16;
    return (l[1:0] == 2'b00) ? 24 : 32;
  endfunction

  function automatic int frame_ticks(input logic [7:0] l);
    return 16 * (1 + 5 + int'(l[1:0]) + int'(l[3])) + stop_ticks(l);
  endfunction

  function automatic logic exp_par(input logic [7:0] b, input logic [7:0] l);
    logic [7:0] m;
    m = b & 8'((1 << (5 + int'(l[1:0]))) - 1);
    if (l[5]) return ~l[4];
    return l[4] ? ^m : ~^m;
  endfunction

  task automatic write_reg(input int a, input logic [7:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 2'(a); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic push(input logic [7:0] b);
    in_valid = 1'b1; in_data = b;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic wait_fall(output int t);
    while (tx_o !== 1'b0) @(negedge clk);
    t = cyc;
  endtask

  // Samples every bit at its centre and compares the whole frame.
  task automatic decode(input int d, input logic [7:0] l, input logic [7:0] b,
                        input string req, output int t0);
    logic [11:0] got, exp;
    int n, nb;
    n  = 5 + int'(l[1:0]);
    nb = 2 + n + int'(l[3]);
    exp = '0; got = '0;
    for (int i = 0; i < n; i++) exp[1+i] = b[i];
    if (l[3]) exp[1+n] = exp_par(b, l);
    exp[nb-1] = 1'b1;
    wait_fall(t0);
    repeat (8*d) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      if (k > 0) repeat (16*d) @(negedge clk);
      got[k] = tx_o;
    end
    check(got == exp, req, int'(got), int'(exp));
  endtask

  // Two back-to-back frames: bits of the first and start-to-start distance.
  task automatic run_pair(input int d, input logic [7:0] l, input logic [7:0] a,
                          input logic [7:0] b, input string bit_req, input string len_req);
    int t1, t2, expd;
    expd = frame_ticks(l) * d + 1;
    fork
      begin push(a); push(b); end
      begin
        decode(d, l, a, bit_req, t1);
        wait_fall(t2);
        check(t2 - t1 == expd, len_req, t2 - t1, expd);
      end
    join
    while (busy_o) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=done", cyc);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] l;
    logic [2:0] pbits;
    int t1, t2, cnt;
    string req;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(tx_o === 1'b1, "R1 tx idle", tx_o, 1);
    check(busy_o === 1'b0, "R1 busy", busy_o, 0);
    check(in_ready === 1'b1, "R1 ready", in_ready, 1);
    run_pair(1, 8'h00, 8'hB5, 8'h4C, "R1 default format", "R1 default length");

    // R2 R3 R4 R5: sweep of word length, stop and parity modes
    for (int c = 0; c < 40; c++) begin
      case (c / 8)
        0: begin pbits = 3'b000; req = "R2"; end
        1: begin pbits = 3'b001; req = "R4 odd"; end
        2: begin pbits = 3'b011; req = "R4 even"; end
        3: begin pbits = 3'b101; req = "R5 fixed one"; end
        default: begin pbits = 3'b111; req = "R5 fixed zero"; end
      endcase
      l = {2'b00, pbits, 1'(c % 2), 2'((c / 2) % 4)};
      write_reg(LCR_A, l);
      run_pair(1, l, 8'(c*53 + 17), 8'(c*91 + 200), req, "R3 stop length");
    end

    // R8 R9: divisor access and bit time
    write_reg(LCR_A, 8'h83);
    write_reg(0, 8'd3);
    write_reg(1, 8'd0);
    write_reg(LCR_A, 8'h0B);
    run_pair(3, 8'h0B, 8'h96, 8'h21, "R8 divisor load bits", "R9 divisor 3 length");
    write_reg(0, 8'd7);
    write_reg(1, 8'd1);
    run_pair(3, 8'h0B, 8'h3C, 8'hE1, "R8 locked bits", "R8 locked divisor length");
    write_reg(LCR_A, 8'h83);
    write_reg(0, 8'd0);
    write_reg(1, 8'd0);
    write_reg(LCR_A, 8'h03);
    run_pair(1, 8'h03, 8'h71, 8'h0F, "R9 zero divisor bits", "R9 zero divisor length");
    write_reg(LCR_A, 8'h83);
    write_reg(0, 8'd1);
    write_reg(LCR_A, 8'h03);

    // R10: format written mid-frame is deferred
    fork
      begin push(8'hC9); push(8'h12); end
      begin
        decode(1, 8'h03, 8'hC9, "R10 frame bits", t1);
        wait_fall(t2);
        check(t2 - t1 == frame_ticks(8'h03) + 1, "R10 frame length", t2 - t1,
              frame_ticks(8'h03) + 1);
      end
      begin
        wait_fall(cnt);
        repeat (40) @(negedge clk);
        write_reg(LCR_A, 8'h08);
      end
    join
    while (busy_o) @(negedge clk);
    write_reg(LCR_A, 8'h03);
    fork
      push(8'h55);
      begin
        wait_fall(t1);
        repeat (20) @(negedge clk);
        // R11: no acceptance during a frame
        check(in_ready === 1'b0 && busy_o === 1'b1, "R11 ready during frame",
              {in_ready, busy_o}, 1);
      end
    join
    while (busy_o) @(negedge clk);

    // R6 R11: break while idle
    write_reg(LCR_A, 8'h43);
    cnt = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (tx_o !== 1'b0) cnt++;
    end
    check(cnt == 0, "R6 idle break low", cnt, 0);
    check(in_ready === 1'b0 && busy_o === 1'b1, "R11 break blocks", {in_ready, busy_o}, 1);
    // R7: rest time after break release
    fork
      push(8'hA6);
      begin
        write_reg(LCR_A, 8'h03);
        cnt = 0;
        forever begin
          @(negedge clk);
          if (tx_o === 1'b1) cnt++;
          else if (cnt > 0) break;
        end
        check(cnt >= 16 && cnt <= 18, "R7 rest after release", cnt, 17);
      end
    join
    while (busy_o) @(negedge clk);

    // R6 R7: break during a frame
    fork
      begin push(8'hFF); push(8'h5A); end
      begin
        wait_fall(t1);
        repeat (40) @(negedge clk);
        write_reg(LCR_A, 8'h43);
        repeat (20) @(negedge clk);
        check(tx_o === 1'b0, "R6 break mid-frame", tx_o, 0);
        write_reg(LCR_A, 8'h03);
        @(negedge clk);
        wait_fall(t2);
        check(t2 - t1 == frame_ticks(8'h03) + 17, "R7 gap after frame", t2 - t1,
              frame_ticks(8'h03) + 17);
      end
    join
    while (busy_o) @(negedge clk);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule